// File: doc/BRIEF.md
# Elapsed-Time and Event Recorder

This block watches one event input and keeps two running totals: how long the input has been active, and how many qualified events have occurred. The active time is a 32-bit count in quarter-second units. The event total is a 16-bit count. Both totals are mirrored into an external nonvolatile store through a simple abstract interface. The block reads the store after reset and again at the start of every event. It writes both totals back when a counted event ends.

An event must stay high for at least `G_CYC` sampled clock cycles to be counted. Time starts to accumulate only after the input has been high for `ES_CYC` cycles. A time tick is produced every `TICK_DIV` pulses of a clock enable, and the divider restarts at each event start. A short event therefore raises the event total without adding time. Both totals saturate at all-ones instead of wrapping.

While a store read is pending, the block raises a data-invalid flag. For a fixed window after each writeback, it raises a busy flag that tells the surrounding bus logic to keep off.

Top module: `evt_time_logger`

## Requirements
- R1: During reset and after it, `data_invalid` and `st_rd_req` are high and `busy` is low until `st_rd_ack` is seen high. On that clock edge, `elapsed_time` and `event_count` take the values on `st_rd_time` and `st_rd_count`.
- R2: A low-to-high change of `evt_in` while idle raises `st_rd_req` and `data_invalid` from the next cycle. When `st_rd_ack` arrives, both totals are reloaded from the store.
- R3: A pulse that is high for fewer than `G_CYC` sampled cycles changes neither total, produces no `st_wr_en` strobe and does not raise `busy`.
- R4: A pulse that is high for at least `G_CYC` sampled cycles adds one to `event_count` when it falls. If the pulse lasted no more than `ES_CYC` cycles, `elapsed_time` is left unchanged.
- R5: Count the clock edge that first samples `evt_in` high as edge 0. With `ce` held high and the store answering within two cycles, `elapsed_time` increases by one at every edge k that is a multiple of `TICK_DIV`, has k ≥ `ES_CYC`, and has `evt_in` still high. With `ce` low, no time is added.
- R6: `elapsed_time` only changes by a step of +1, and only at an edge where `evt_in` is sampled high. Store reloads are the exception.
- R7: When a counted event ends, `st_wr_en` is high for exactly one cycle. In that cycle, `st_wr_time` and `st_wr_count` carry the updated totals, and `busy` rises in the same cycle.
- R8: `busy` stays high for exactly `EW_CYC` cycles after each writeback starts. `busy` and `data_invalid` are never high together.
- R9: `elapsed_time` stops at 32'hFFFFFFFF and never rolls over.
- R10: `event_count` stops at 16'hFFFF and never rolls over.
- R11: If `evt_in` rises while `busy` is high and is still high when the window closes, that activity is not treated as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Event input, synchronous to clk |
| ce | input | 1 | Clock enable feeding the quarter-second divider |
| st_rd_ack | input | 1 | Store read data valid |
| st_rd_time | input | 32 | Stored elapsed time |
| st_rd_count | input | 16 | Stored event count |
| st_rd_req | output | 1 | Store read request, held until acknowledged |
| st_wr_en | output | 1 | One-cycle store write strobe |
| st_wr_time | output | 32 | Elapsed time to be stored |
| st_wr_count | output | 16 | Event count to be stored |
| elapsed_time | output | 32 | Working elapsed-time total |
| event_count | output | 16 | Working event total |
| data_invalid | output | 1 | Totals are being loaded and must not be trusted |
| busy | output | 1 | Writeback window active |

## Verification
The bound checker enforces several rules on every cycle:
- the step-by-one and no-wrap rules for both totals;
- that time advances only while the input is high;
- that every writeback strobe opens the busy window;
- that the window lasts exactly `EW_CYC` cycles;
- that busy and invalid never overlap.

Other behaviours depend on pulse lengths and store contents, so only the bench scenarios can show them:
- which pulse lengths count as events;
- how much time each pulse adds;
- the reload of store values at boot and at every event start;
- the effect of a gated clock enable;
- that a rise during the busy window is ignored.

// File: rtl/etr_pkg.sv
package etr_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_LOAD,
        ST_ACTIVE,
        ST_WRITE
    } etr_state_e;

endpackage

// File: rtl/etr_sat_inc.sv
// Saturating +1: returns the input unchanged when it is already all-ones.
module etr_sat_inc #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc
);

    always_comb begin
        if (&val) begin
            inc = val;
        end else begin
            inc = val + 1'b1;
        end
    end

endmodule

// File: rtl/etr_tick_div.sv
// Divides clock-enable pulses down to one tick per DIV pulses while running.
module etr_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic ce,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && ce && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && ce) begin
            cnt_d = tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/evt_time_logger.sv
// Elapsed-time and event recorder with store handshake.
// Parameter constraints: 1 <= G_CYC <= ES_CYC, ES_CYC >= 3, EW_CYC >= 1, TICK_DIV >= 2.
module evt_time_logger
    import etr_pkg::*;
#(
    parameter int TIME_W   = 32,
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 8192,
    parameter int G_CYC    = 16,
    parameter int ES_CYC   = 256,
    parameter int EW_CYC   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              ce,
    input  logic              st_rd_ack,
    input  logic [TIME_W-1:0] st_rd_time,
    input  logic [CNT_W-1:0]  st_rd_count,
    output logic              st_rd_req,
    output logic              st_wr_en,
    output logic [TIME_W-1:0] st_wr_time,
    output logic [CNT_W-1:0]  st_wr_count,
    output logic [TIME_W-1:0] elapsed_time,
    output logic [CNT_W-1:0]  event_count,
    output logic              data_invalid,
    output logic              busy
);

    localparam int HI_W = $clog2(ES_CYC + 1);
    localparam int EW_W = $clog2(EW_CYC + 1);

    typedef struct packed {
        etr_state_e         state;
        logic               evt;
        logic [HI_W-1:0]    hi;
        logic               ended;
        logic [TIME_W-1:0]  etime;
        logic [CNT_W-1:0]   ecnt;
        logic [EW_W-1:0]    ew;
        logic               wr;
    } regs_t;

    regs_t r_d, r_q;

    logic              rise;
    logic              in_event;
    logic              tick;
    logic [TIME_W-1:0] time_inc;
    logic [CNT_W-1:0]  cnt_inc;

    assign rise     = evt_in && !r_q.evt;
    assign in_event = (r_q.state == ST_LOAD) || (r_q.state == ST_ACTIVE);

    etr_tick_div #(
        .DIV (TICK_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((r_q.state == ST_IDLE) && rise),
        .run   (in_event),
        .ce    (ce),
        .tick  (tick)
    );

    etr_sat_inc #(.W(TIME_W)) u_time_inc (.val(r_q.etime), .inc(time_inc));
    etr_sat_inc #(.W(CNT_W))  u_cnt_inc  (.val(r_q.ecnt),  .inc(cnt_inc));

    always_comb begin
        r_d     = r_q;
        r_d.evt = evt_in;
        r_d.wr  = 1'b0;

        if (in_event) begin
            if (!r_q.ended && evt_in && (r_q.hi != HI_W'(ES_CYC))) begin
                r_d.hi = r_q.hi + 1'b1;
            end
            if (!evt_in) begin
                r_d.ended = 1'b1;
            end
        end

        case (r_q.state)
            ST_BOOT: begin
                if (st_rd_ack) begin
                    r_d.etime = st_rd_time;
                    r_d.ecnt  = st_rd_count;
                    r_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (rise) begin
                    r_d.state = ST_LOAD;
                    r_d.hi    = HI_W'(1);
                    r_d.ended = 1'b0;
                end
            end
            ST_LOAD: begin
                if (st_rd_ack) begin
                    r_d.etime = st_rd_time;
                    r_d.ecnt  = st_rd_count;
                    r_d.state = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (r_q.ended || !evt_in) begin
                    if (r_q.hi >= HI_W'(G_CYC)) begin
                        r_d.ecnt  = cnt_inc;
                        r_d.wr    = 1'b1;
                        r_d.ew    = EW_W'(EW_CYC - 1);
                        r_d.state = ST_WRITE;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end else if (tick && (r_q.hi == HI_W'(ES_CYC))) begin
                    r_d.etime = time_inc;
                end
            end
            ST_WRITE: begin
                if (r_q.ew == '0) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.ew = r_q.ew - 1'b1;
                end
            end
            default: begin
                r_d.state = ST_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_BOOT;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_rd_req    = (r_q.state == ST_BOOT) || (r_q.state == ST_LOAD);
    assign data_invalid = (r_q.state == ST_BOOT) || (r_q.state == ST_LOAD);
    assign busy         = (r_q.state == ST_WRITE);
    assign st_wr_en     = r_q.wr;
    assign st_wr_time   = r_q.etime;
    assign st_wr_count  = r_q.ecnt;
    assign elapsed_time = r_q.etime;
    assign event_count  = r_q.ecnt;

endmodule

// File: rtl/etr_checker.sv
module etr_checker #(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16,
    parameter int EW_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_in,
    input logic [TIME_W-1:0] elapsed_time,
    input logic [CNT_W-1:0]  event_count,
    input logic              data_invalid,
    input logic              busy,
    input logic              st_wr_en
);

    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!busy) begin
            run_q <= '0;
        end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R6: time moves only by +1 and only when the input was sampled high
    p_time_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(data_invalid) && (elapsed_time != $past(elapsed_time)))
        |-> ((elapsed_time == $past(elapsed_time) + 1'b1) && $past(evt_in)));

    // R9: no wrap of the time total
    p_time_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(data_invalid) && (&$past(elapsed_time))) |-> (&elapsed_time));

    // R10: no wrap of the event total
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(data_invalid) && (&$past(event_count))) |-> (&event_count));

    // R4 / R7: count steps by one, together with a write strobe
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(data_invalid) && (event_count != $past(event_count)))
        |-> ((event_count == $past(event_count) + 1'b1) && st_wr_en));

    // R7: every writeback opens the busy window
    p_wr_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> st_wr_en);

    // R8: busy window length
    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == 32'(EW_CYC - 1)));

    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 32'(EW_CYC)));

    // R8: flags exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && data_invalid));

endmodule

bind evt_time_logger etr_checker #(
    .TIME_W (TIME_W),
    .CNT_W  (CNT_W),
    .EW_CYC (EW_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_in       (evt_in),
    .elapsed_time (elapsed_time),
    .event_count  (event_count),
    .data_invalid (data_invalid),
    .busy         (busy),
    .st_wr_en     (st_wr_en)
);

// File: tb/evt_time_logger_tb.sv
`timescale 1ns/1ps
module evt_time_logger_tb;

    localparam int DIV = 4;
    localparam int G   = 3;
    localparam int ES  = 8;
    localparam int EW  = 5;

    typedef struct packed {
        int unsigned len;
        int unsigned dt;
        bit          cnt;
    } vec_t;

    // pulse length, time added, counted (G=3, ES=8, DIV=4)
    localparam vec_t VECS [9] = '{
        '{1, 0, 1'b0}, '{2, 0, 1'b0}, '{3, 0, 1'b1},
        '{7, 0, 1'b1}, '{8, 0, 1'b1}, '{9, 1, 1'b1},
        '{12, 1, 1'b1}, '{13, 2, 1'b1}, '{30, 6, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic        ce = 1'b1;
    logic        st_rd_ack = 1'b0;
    logic [31:0] st_rd_time;
    logic [15:0] st_rd_count;
    logic        st_rd_req, st_wr_en, data_invalid, busy;
    logic [31:0] st_wr_time, elapsed_time;
    logic [15:0] st_wr_count, event_count;

    logic [31:0] mem_time = '0;
    logic [15:0] mem_cnt = '0;
    logic        pre_go = 1'b0;
    logic [31:0] pre_t = '0;
    logic [15:0] pre_c = '0;

    int checks = 0;
    int fails = 0;
    logic [31:0] exp_t;
    logic [15:0] exp_c;

    always #2 clk = ~clk;

    evt_time_logger #(
        .TIME_W(32), .CNT_W(16), .TICK_DIV(DIV),
        .G_CYC(G), .ES_CYC(ES), .EW_CYC(EW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ce(ce),
        .st_rd_ack(st_rd_ack), .st_rd_time(st_rd_time), .st_rd_count(st_rd_count),
        .st_rd_req(st_rd_req), .st_wr_en(st_wr_en), .st_wr_time(st_wr_time),
        .st_wr_count(st_wr_count), .elapsed_time(elapsed_time),
        .event_count(event_count), .data_invalid(data_invalid), .busy(busy)
    );

    // store model
    assign st_rd_time  = mem_time;
    assign st_rd_count = mem_cnt;
    always @(posedge clk) begin
        st_rd_ack <= st_rd_req;
        if (pre_go) begin
            mem_time <= pre_t;
            mem_cnt  <= pre_c;
        end else if (st_wr_en) begin
            mem_time <= st_wr_time;
            mem_cnt  <= st_wr_count;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preset(input logic [31:0] t, input logic [15:0] c);
        @(negedge clk);
        pre_t = t; pre_c = c; pre_go = 1'b1;
        @(negedge clk);
        pre_go = 1'b0;
    endtask

    task automatic pulse(input int n, input bit counted, input string tag);
        int bc;
        @(negedge clk) evt_in = 1'b1;
        repeat (n) @(negedge clk);
        evt_in = 1'b0;
        @(negedge clk);
        chk({tag, " R7 strobe"}, 32'(st_wr_en), 32'(counted));
        if (counted) chk("R7 wr count", 32'(st_wr_count), 32'(exp_c + 16'd1 == 16'd0 ? exp_c : exp_c + 16'd1));
        bc = int'(busy);
        repeat (EW + 4) begin
            @(negedge clk);
            bc += int'(busy);
        end
        chk({tag, " R8 busy length"}, 32'(bc), counted ? 32'(EW) : 32'd0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset / boot load
        preset(32'h0000_0100, 16'd7);
        @(negedge clk);
        chk("R1 invalid in reset", 32'(data_invalid), 32'd1);
        chk("R1 rd_req in reset", 32'(st_rd_req), 32'd1);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 boot time", elapsed_time, 32'h100);
        chk("R1 boot count", 32'(event_count), 32'd7);
        chk("R1 invalid cleared", 32'(data_invalid), 32'd0);
        exp_t = 32'h100;
        exp_c = 16'd7;

        // R3 R4 R5 R7 R8: vector table
        for (int i = 0; i < 9; i++) begin
            pulse(int'(VECS[i].len), VECS[i].cnt, VECS[i].cnt ? "R4" : "R3");
            exp_t = exp_t + VECS[i].dt;
            exp_c = exp_c + 16'(VECS[i].cnt);
            chk(VECS[i].cnt ? "R5 time" : "R3 time", elapsed_time, exp_t);
            chk(VECS[i].cnt ? "R4 count" : "R3 count", 32'(event_count), 32'(exp_c));
            chk("R7 store time", mem_time, exp_t);
            chk("R7 store count", 32'(mem_cnt), 32'(exp_c));
        end

        // R5: no ticks with ce low
        ce = 1'b0;
        pulse(30, 1'b1, "R5 ce low");
        exp_c = exp_c + 16'd1;
        chk("R5 ce low time", elapsed_time, exp_t);
        chk("R4 ce low count", 32'(event_count), 32'(exp_c));
        ce = 1'b1;

        // R2: reload at event start, invalid during load
        preset(32'h0000_0042, 16'd3);
        @(negedge clk) evt_in = 1'b1;
        @(negedge clk);
        chk("R2 invalid on load", 32'(data_invalid), 32'd1);
        chk("R2 rd_req on load", 32'(st_rd_req), 32'd1);
        repeat (3) @(negedge clk);
        chk("R2 invalid cleared", 32'(data_invalid), 32'd0);
        chk("R2 reloaded time", elapsed_time, 32'h42);
        evt_in = 1'b0;
        repeat (EW + 6) @(negedge clk);
        chk("R2 count after reload", 32'(event_count), 32'd4);
        exp_t = 32'h42;
        exp_c = 16'd4;

        // R11: rise inside busy window ignored
        @(negedge clk) evt_in = 1'b1;
        repeat (12) @(negedge clk);
        evt_in = 1'b0;
        @(negedge clk);
        chk("R11 busy open", 32'(busy), 32'd1);
        evt_in = 1'b1;
        repeat (12) @(negedge clk);
        evt_in = 1'b0;
        repeat (EW + 6) @(negedge clk);
        chk("R11 count", 32'(event_count), 32'(exp_c + 16'd1));
        chk("R11 time", elapsed_time, exp_t + 32'd1);
        chk("R11 store count", 32'(mem_cnt), 32'(exp_c + 16'd1));

        // R9: time saturation
        preset(32'hFFFF_FFFE, 16'd10);
        exp_c = 16'd10;
        pulse(30, 1'b1, "R9");
        chk("R9 time saturated", elapsed_time, 32'hFFFF_FFFF);
        chk("R9 count", 32'(event_count), 32'd11);

        // R10: count saturation
        preset(32'd5, 16'hFFFF);
        exp_c = 16'hFFFF;
        pulse(9, 1'b1, "R10");
        chk("R10 count saturated", 32'(event_count), 32'hFFFF);
        chk("R10 time", elapsed_time, 32'd6);
        chk("R10 store count", 32'(mem_cnt), 32'hFFFF);

        finish_run();
    end

endmodule